// File: doc/BRIEF.md
# Bird Position, Collision and Score Unit

This unit keeps the game state of a side-scrolling obstacle game for the single display column where the player's bird lives. The bird's height is a small saturating up/down counter. It advances one row on each bird tick: upward while the flap level is held, downward otherwise. The height is published as a one-hot row vector. That vector is ANDed with the wall bits currently sitting in the bird's column to detect a crash.

A crash is latched. It freezes the bird and the score until the next start pulse, and that pulse also re-centres the bird. The unit counts a wall as cleared when a non-empty wall column seen on one tick is followed by an empty column on the next tick with no crash in between. The score drives an active-low seven-segment digit that goes blank beyond nine. All outputs come from registers and change on the clock edge that samples the cause.

Top module: `flap_bird_core`

## Requirements
- R1: The bird row changes only on cycles where `tick` is high; with `tick` low and no start, all outputs hold.
- R2: On a tick with `flap` high the row rises by one, with `flap` low it falls by one, holding at 7 at the top and at 0 at the bottom instead of wrapping.
- R3: Reset or a `start` pulse puts the bird at row 4, clears the crash flag and the score; `start` overrides a tick in the same cycle.
- R4: `bird_row` is one-hot: bit k is high exactly when the bird is at row k (bit 0 is the bottom row).
- R5: On a tick where the `wall` bit at the bird's current row is set, `crash` is high from the next cycle, and the bird does not move on that tick.
- R6: Once set, `crash` stays high until `start`; while it is high, ticks do not move the bird.
- R7: The score rises by one on a tick where `wall` is all zero, the wall sampled on the previous tick was non-zero, and no crash is latched.
- R8: The score does not change while `crash` is high, and it saturates at 15.
- R9: `seg_n` is active-low with bit 0 = segment a through bit 6 = segment g, showing digits 0 to 9 in standard form and updating in the same cycle as `score`.
- R10: For a score above 9, all `seg_n` bits are high (blank digit).
- R11: `wall` is sampled only on ticks; a wall shown only on non-tick cycles neither crashes the bird nor arms a score.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Bird step strobe, one cycle wide |
| flap | input | 1 | Flap level, high = climb |
| start | input | 1 | New-game pulse |
| wall | input | 8 | Wall bits in the bird's column, bit k = row k |
| bird_row | output | 8 | One-hot bird row |
| crash | output | 1 | Latched collision flag |
| score | output | 4 | Walls cleared |
| seg_n | output | 7 | Active-low segments, bit 0 = a to bit 6 = g |

## Verification
Several functions can land on the same tick: a collision and a position step, and a start pulse and a tick. The bench provokes both pairs. It holds `flap` high on the tick where a wall bit covers the bird's row, and it raises `start` together with `tick` while the game is crashed. In the first case it expects the crash flag set with the row unchanged. In the second it expects the row at 4, the crash cleared and the score zero. A cycle-level model of the rules predicts every output after each edge, and sweeps climb and fall past both rails, score walls up to saturation and test crashes at the top and bottom rows.

// File: rtl/bird_pkg.sv
package bird_pkg;

  // Active-low seven-segment pattern, bit 0 = a ... bit 6 = g; blank above nine.
  function automatic logic [6:0] seg_of(input int unsigned value);
    logic [6:0] lit;
    case (value)
      0:       lit = 7'h3F;
      1:       lit = 7'h06;
      2:       lit = 7'h5B;
      3:       lit = 7'h4F;
      4:       lit = 7'h66;
      5:       lit = 7'h6D;
      6:       lit = 7'h7D;
      7:       lit = 7'h07;
      8:       lit = 7'h7F;
      9:       lit = 7'h6F;
      default: lit = 7'h00;
    endcase
    return ~lit;
  endfunction

endpackage

// File: rtl/bird_pos.sv
module bird_pos #(
  parameter int POS_W     = 3,
  parameter int START_ROW = 4,
  localparam int ROWS     = 2 ** POS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             tick,
  input  logic             flap,
  input  logic             hold,
  output logic [POS_W-1:0] pos_q,
  output logic [ROWS-1:0]  onehot_q
);

  localparam logic [POS_W-1:0] TOP  = POS_W'(ROWS - 1);
  localparam logic [POS_W-1:0] HOME = POS_W'(START_ROW);

  logic [POS_W-1:0] pos_d;
  logic [ROWS-1:0]  onehot_d;

  always_comb begin
    pos_d = pos_q;
    if (start) begin
      pos_d = HOME;
    end else if (tick && !hold) begin
      if (flap) begin
        if (pos_q != TOP) pos_d = pos_q + 1'b1;
      end else begin
        if (pos_q != '0) pos_d = pos_q - 1'b1;
      end
    end
  end

  for (genvar k = 0; k < ROWS; k++) begin : g_dec
    assign onehot_d[k] = (pos_d == POS_W'(k));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q    <= HOME;
      onehot_q <= ROWS'(1) << START_ROW;
    end else begin
      pos_q    <= pos_d;
      onehot_q <= onehot_d;
    end
  end

  AST_START_HOME: assert property (@(posedge clk) disable iff (rst)
    start |=> pos_q == HOME); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!tick && !start) |=> $stable(pos_q)); // R1
  AST_TOP_RAIL: assert property (@(posedge clk) disable iff (rst)
    (pos_q == TOP && flap && !start) |=> pos_q == TOP); // R2
  AST_BOTTOM_RAIL: assert property (@(posedge clk) disable iff (rst)
    (pos_q == '0 && !flap && !start) |=> pos_q == '0); // R2
  AST_ONE_ROW: assert property (@(posedge clk) disable iff (rst)
    $countones(onehot_q) == 1); // R4
  AST_ROW_MATCH: assert property (@(posedge clk) disable iff (rst)
    onehot_q[pos_q] == 1'b1); // R4

endmodule

// File: rtl/bird_hit.sv
module bird_hit #(
  parameter int ROWS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            tick,
  input  logic [ROWS-1:0] row_oh,
  input  logic [ROWS-1:0] wall,
  output logic            hit,
  output logic            crash_q
);

  assign hit = tick && (|(row_oh & wall));

  always_ff @(posedge clk) begin
    if (rst || start) begin
      crash_q <= 1'b0;
    end else if (hit) begin
      crash_q <= 1'b1;
    end
  end

  AST_HIT_LATCHES: assert property (@(posedge clk) disable iff (rst)
    (hit && !start) |=> crash_q); // R5
  AST_CRASH_STICKY: assert property (@(posedge clk) disable iff (rst)
    (crash_q && !start) |=> crash_q); // R6
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> !crash_q); // R3

endmodule

// File: rtl/bird_score.sv
module bird_score #(
  parameter int ROWS    = 8,
  parameter int SCORE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               tick,
  input  logic [ROWS-1:0]    wall,
  input  logic               hit,
  input  logic               crashed,
  output logic [SCORE_W-1:0] score_d,
  output logic [SCORE_W-1:0] score_q
);

  localparam logic [SCORE_W-1:0] FULL = {SCORE_W{1'b1}};

  logic armed_q;
  logic armed_d;
  logic live_tick;

  assign live_tick = tick && !crashed && !hit;

  always_comb begin
    score_d = score_q;
    armed_d = armed_q;
    if (start) begin
      score_d = '0;
      armed_d = 1'b0;
    end else if (live_tick) begin
      if (armed_q && (wall == '0) && (score_q != FULL)) score_d = score_q + 1'b1;
      armed_d = |wall;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      score_q <= '0;
      armed_q <= 1'b0;
    end else begin
      score_q <= score_d;
      armed_q <= armed_d;
    end
  end

  AST_FROZEN_ON_CRASH: assert property (@(posedge clk) disable iff (rst)
    (crashed && !start) |=> $stable(score_q)); // R8
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (score_q == FULL && !start) |=> score_q == FULL); // R8
  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    !start |=> (score_q == $past(score_q)) || (score_q == $past(score_q) + 1'b1)); // R7
  AST_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    (!tick && !start) |=> $stable(score_q)); // R11

endmodule

// File: rtl/bird_seg.sv
module bird_seg #(
  parameter int SCORE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SCORE_W-1:0] value_d,
  output logic [6:0]         seg_n_q
);

  import bird_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_n_q <= seg_of(0);
    end else begin
      seg_n_q <= seg_of(int'(value_d));
    end
  end

endmodule

// File: rtl/flap_bird_core.sv
module flap_bird_core #(
  parameter int POS_W     = 3,
  parameter int SCORE_W   = 4,
  parameter int START_ROW = 2 ** (POS_W - 1),
  localparam int ROWS     = 2 ** POS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tick,
  input  logic               flap,
  input  logic               start,
  input  logic [ROWS-1:0]    wall,
  output logic [ROWS-1:0]    bird_row,
  output logic               crash,
  output logic [SCORE_W-1:0] score,
  output logic [6:0]         seg_n
);

  logic [POS_W-1:0]   pos_q;
  logic               hit;
  logic [SCORE_W-1:0] score_d;

  bird_pos #(
    .POS_W     (POS_W),
    .START_ROW (START_ROW)
  ) i_pos (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .tick     (tick),
    .flap     (flap),
    .hold     (hit || crash),
    .pos_q    (pos_q),
    .onehot_q (bird_row)
  );

  bird_hit #(
    .ROWS (ROWS)
  ) i_hit (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .tick    (tick),
    .row_oh  (bird_row),
    .wall    (wall),
    .hit     (hit),
    .crash_q (crash)
  );

  bird_score #(
    .ROWS    (ROWS),
    .SCORE_W (SCORE_W)
  ) i_score (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .tick    (tick),
    .wall    (wall),
    .hit     (hit),
    .crashed (crash),
    .score_d (score_d),
    .score_q (score)
  );

  bird_seg #(
    .SCORE_W (SCORE_W)
  ) i_seg (
    .clk     (clk),
    .rst     (rst),
    .value_d (score_d),
    .seg_n_q (seg_n)
  );

  AST_BLANK_ABOVE_NINE: assert property (@(posedge clk) disable iff (rst)
    (int'(score) > 9) |-> seg_n == 7'h7F); // R10
  AST_CRASH_FREEZES_BIRD: assert property (@(posedge clk) disable iff (rst)
    (crash && !start) |=> $stable(bird_row)); // R6
  AST_ZERO_SHOWS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (score == '0) |-> seg_n == 7'h40); // R9

endmodule

// File: tb/test_flap_bird_core.sv
module test_flap_bird_core;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       flap = 1'b0;
  logic       start = 1'b0;
  logic [7:0] wall = 8'h00;
  logic [7:0] bird_row;
  logic       crash;
  logic [3:0] score;
  logic [6:0] seg_n;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // model state
  int mp = 4;
  bit mc = 1'b0;
  int ms = 0;
  bit marm = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  flap_bird_core i_flap_bird_core (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .flap     (flap),
    .start    (start),
    .wall     (wall),
    .bird_row (bird_row),
    .crash    (crash),
    .score    (score),
    .seg_n    (seg_n)
  );

  function automatic logic [6:0] exp_seg(input int v);
    logic [6:0] on;
    case (v)
      0: on = 7'b0111111;
      1: on = 7'b0000110;
      2: on = 7'b1011011;
      3: on = 7'b1001111;
      4: on = 7'b1100110;
      5: on = 7'b1101101;
      6: on = 7'b1111101;
      7: on = 7'b0000111;
      8: on = 7'b1111111;
      9: on = 7'b1101111;
      default: on = 7'b0000000;
    endcase
    return ~on;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    check(tag, "bird_row (R4)", int'(bird_row), 1 << mp);
    check(tag, "crash (R5 R6)", int'(crash), int'(mc));
    check(tag, "score (R7 R8)", int'(score), ms);
    check(tag, "seg_n (R9 R10)", int'(seg_n), int'(exp_seg(ms)));
  endtask

  // drive at negedge, model the edge, come back to the next negedge
  task automatic cyc(input bit t, input bit f, input bit s, input logic [7:0] w);
    bit h;
    tick = t; flap = f; start = s; wall = w;
    @(posedge clk);
    if (s) begin
      mp = 4; mc = 1'b0; ms = 0; marm = 1'b0;
    end else if (t && !mc) begin
      h = w[mp];
      if (h) begin
        mc = 1'b1;
      end else begin
        if (f && mp < 7) mp++;
        else if (!f && mp > 0) mp--;
        if (marm && w == 8'h00 && ms < 15) ms++;
        marm = (w != 8'h00);
      end
    end
    @(negedge clk);
    tick = 1'b0; start = 1'b0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R3 reset");

    // R2 climb to the top rail with idle cycles between ticks (R1)
    for (int i = 0; i < 6; i++) begin
      cyc(1'b1, 1'b1, 1'b0, 8'h00);
      check_all("R2 climb");
      cyc(1'b0, 1'b0, 1'b0, 8'hFF);
      check_all("R1 no tick");
    end
    // R2 fall to the bottom rail and beyond
    for (int i = 0; i < 10; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 8'h00);
      check_all("R2 fall");
    end

    // R3 start re-centres
    cyc(1'b0, 1'b0, 1'b1, 8'h00);
    check_all("R3 start");

    // R7 R8 R10 score sweep to saturation through every digit
    for (int k = 0; k < 18; k++) begin
      cyc(1'b1, k[0], 1'b0, 8'hFF ^ (8'h01 << mp));
      check_all("R7 wall at bird");
      cyc(1'b1, ~k[0], 1'b0, 8'h00);
      check_all("R7 wall cleared");
    end

    // R11 wall seen only off-tick does not arm or crash
    cyc(1'b0, 1'b0, 1'b1, 8'h00);
    check_all("R3 restart");
    cyc(1'b0, 1'b0, 1'b0, 8'hFF);
    check_all("R11 off-tick wall");
    cyc(1'b1, 1'b1, 1'b0, 8'h00);
    check_all("R11 no score");

    // R5 collision with flap on the same tick: bird stays put
    cyc(1'b1, 1'b1, 1'b0, 8'h01 << mp);
    check_all("R5 hit");
    // R6 crashed: ticks, walls and clears have no effect
    for (int i = 0; i < 4; i++) begin
      cyc(1'b1, i[0], 1'b0, (i % 2 == 0) ? 8'h0F : 8'h00);
      check_all("R6 frozen");
    end

    // R3 start together with a tick while crashed
    cyc(1'b1, 1'b1, 1'b1, 8'hFF);
    check_all("R3 start beats tick");

    // R5 crash at bottom row
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00);
    check_all("R2 bottom");
    cyc(1'b1, 1'b0, 1'b0, 8'h01);
    check_all("R5 bottom hit");

    // R5 crash at top row after scoring once
    cyc(1'b0, 1'b0, 1'b1, 8'h00);
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 1'b0, 8'h00);
    cyc(1'b1, 1'b1, 1'b0, 8'h7F);
    cyc(1'b1, 1'b1, 1'b0, 8'h00);
    check_all("R7 one wall");
    cyc(1'b1, 1'b1, 1'b0, 8'h80);
    check_all("R5 top hit");
    cyc(1'b1, 1'b0, 1'b0, 8'h00);
    check_all("R8 frozen score");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule